// File: doc/BRIEF.md
# Test Pattern Address Sequencer

This block produces the vector memory address for a digital tester's pattern engine. Each vector carries one flow opcode. The instruction fields that belong to the current address (opcode, target address and count) are presented combinationally. The sequencer decides the next address in the same cycle, so it issues one address per clock and a taken branch costs no extra cycle.

The flow model covers the following:
- counted loops and match loops, which nest on a loop-counter stack;
- break and continue;
- unconditional jumps;
- branches on the pass/fail flag;
- subroutine calls, which nest on a return-address stack.

A stop instruction parks the sequencer and raises a done output until the handler acknowledges. Stack overflow or underflow freezes the sequencer and raises a sticky error. A match loop that uses up its iteration limit without seeing a match exits and pulses a timeout output.

Top module: `pat_seq`

## Requirements
- R1: After a synchronous active-low reset, `addr_o` is 0 and `done_o`, `err_o` and `tmo_o` are low.
- R2: Opcode 0 (advance), and any code from 12 to 15, move the address to address+1 in the next cycle.
- R3: Counted loop. A loop-begin (opcode 1, count C) pushes an entry and moves to address+1. The body runs from the following address through the loop-end (opcode 3). It executes max(C,1) times, one address per cycle, and then execution continues after the loop-end.
- R4: Match loop. A match-loop-begin (opcode 2, count M) opens a loop whose loop-end exits when `match_i` is high in the loop-end cycle. It runs at most max(M,1) iterations. Exiting at that limit without a match pulses `tmo_o` for one cycle, aligned with the exit address. `tmo_o` stays low on every other cycle.
- R5: A jump (opcode 6) moves to `tgt_i`.
- R6: A break (opcode 5) pops the innermost loop entry and moves to `tgt_i`. An enclosing loop then keeps counting its own iterations.
- R7: A continue (opcode 4) behaves as follows:
  - If the innermost loop has iterations left, it consumes one and returns to the first body address.
  - Otherwise it pops the entry and moves to `tgt_i`.
- R8: Flag branches:
  - Opcode 7 moves to `tgt_i` when `flag_i` is 1.
  - Opcode 8 moves to `tgt_i` when `flag_i` is 0.
  - Otherwise both move to address+1.
- R9: A call (opcode 9) pushes address+1 and moves to `tgt_i`. A return (opcode 10) pops that address and moves there. Calls nest up to DEPTH levels.
- R10: A stop (opcode 11) behaves as follows:
  - It raises `done_o` from the next cycle on and holds the address while `ack_i` is low.
  - A cycle with `ack_i` high moves to address+1 and drops `done_o`.
- R11: Fault and halt:
  - A push onto a stack that already holds DEPTH entries is an overflow. A pop or loop-end, continue, break or return on an empty stack is an underflow.
  - Either fault sets `err_o` and freezes the address; `ack_i` then has no effect.
  - Only reset clears this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Opcode of the vector at `addr_o` |
| tgt_i | input | AW | Target address of that vector |
| cnt_i | input | CW | Loop count or match-loop limit of that vector |
| match_i | input | 1 | Comparator match condition |
| flag_i | input | 1 | Pass/fail flag for conditional branches |
| ack_i | input | 1 | Handler acknowledge of a stop |
| addr_o | output | AW | Current vector address |
| done_o | output | 1 | Pattern stopped, waiting for acknowledge |
| err_o | output | 1 | Sticky stack fault, sequencer halted |
| tmo_o | output | 1 | One-cycle match-loop timeout pulse |

## Verification
The assertions check, on every cycle, the single-instruction effects that are visible at the ports:
- advance, jump and taken flag branches land on the right address;
- a stop raises done and holds the address until acknowledge;
- an error is sticky and freezes the address;
- a timeout never coincides with a halt or a stop.

The behaviours that depend on stack state can only be shown by the bench's scenarios, which compare whole address traces. These are loop and match-loop iteration counts, nesting of calls inside loops, break and continue popping the right entry, and overflow or underflow after a given history of pushes.

// File: rtl/pat_seq_pkg.sv
// Package: shared opcode and state encodings for the pattern address sequencer.
// Assumes a 4-bit opcode field; codes not listed behave as advance.
package pat_seq_pkg;

    typedef enum logic [3:0] {
        OP_ADV   = 4'd0,
        OP_LOOP  = 4'd1,
        OP_MLOOP = 4'd2,
        OP_END   = 4'd3,
        OP_CONT  = 4'd4,
        OP_BRK   = 4'd5,
        OP_JMP   = 4'd6,
        OP_BRP   = 4'd7,
        OP_BRF   = 4'd8,
        OP_CALL  = 4'd9,
        OP_RET   = 4'd10,
        OP_STOP  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DONE = 2'd1,
        ST_HALT = 2'd2
    } st_e;

endpackage

// File: rtl/pat_seq_lifo.sv
// Module: pat_seq_lifo
// Last-in first-out store with push, pop and rewrite of the top entry.
// Assumes the caller never pushes when full nor pops when empty; such
// requests are ignored here and reported as faults by the caller.
// Storage cells carry no reset; only the occupancy count does.
module pat_seq_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         upd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]    mem [DEPTH];
    logic [CNTW-1:0] fill;
    logic [IW-1:0]   top_ix;
    logic [IW-1:0]   wr_ix;

    assign top_ix = IW'(fill - 1'b1);
    assign wr_ix  = IW'(fill);
    assign empty  = (fill == '0);
    assign full   = (fill == CNTW'(DEPTH));
    assign top    = empty ? '0 : mem[top_ix];

    // Occupancy count: rises on push, falls on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (push && !full)
            fill <= fill + 1'b1;
        else if (pop && !empty)
            fill <= fill - 1'b1;
    end

    // Entry storage: push writes above the top, update rewrites the top.
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_ix] <= wdata;
        else if (upd && !empty)
            mem[top_ix] <= wdata;
    end

endmodule

// File: rtl/pat_seq_next.sv
// Module: pat_seq_next
// Combinational flow decision: from the current opcode, fields, flags and
// stack tops, picks the next address and the stack operations.
// Loop entry layout: {is_match, first body address, iterations left - 1}.
// Assumes the caller applies the stack requests only while running.
module pat_seq_next
    import pat_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 16
) (
    input  logic [3:0]       op,
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    tgt,
    input  logic [CW-1:0]    cnt,
    input  logic             match,
    input  logic             flag,
    input  logic [AW+CW:0]   lp_top,
    input  logic             lp_empty,
    input  logic             lp_full,
    input  logic [AW-1:0]    rs_top,
    input  logic             rs_empty,
    input  logic             rs_full,
    output logic [AW-1:0]    nxt_addr,
    output logic             lp_push,
    output logic             lp_pop,
    output logic             lp_upd,
    output logic [AW+CW:0]   lp_wdata,
    output logic             rs_push,
    output logic             rs_pop,
    output logic [AW-1:0]    rs_wdata,
    output logic             stop_hit,
    output logic             fault,
    output logic             tmo_hit
);
    logic [AW-1:0] inc;
    logic          e_match;
    logic [AW-1:0] e_start;
    logic [CW-1:0] e_rem;
    logic [AW-1:0] exit_a;
    logic [CW-1:0] first_rem;

    assign inc       = addr + 1'b1;
    assign e_match   = lp_top[AW+CW];
    assign e_start   = lp_top[AW+CW-1:CW];
    assign e_rem     = lp_top[CW-1:0];
    assign exit_a    = (op == OP_END) ? inc : tgt;
    assign first_rem = (cnt == '0) ? '0 : cnt - 1'b1;

    // Decode the opcode into next address, stack requests and events.
    always_comb begin
        nxt_addr = inc;
        lp_push  = 1'b0;
        lp_pop   = 1'b0;
        lp_upd   = 1'b0;
        lp_wdata = '0;
        rs_push  = 1'b0;
        rs_pop   = 1'b0;
        rs_wdata = inc;
        stop_hit = 1'b0;
        fault    = 1'b0;
        tmo_hit  = 1'b0;
        case (op)
            OP_LOOP, OP_MLOOP: begin
                if (lp_full) begin
                    fault = 1'b1;
                end else begin
                    lp_push  = 1'b1;
                    lp_wdata = {op == OP_MLOOP, inc, first_rem};
                end
            end
            OP_END, OP_CONT: begin
                if (lp_empty) begin
                    fault = 1'b1;
                end else if (e_match && match) begin
                    lp_pop   = 1'b1;
                    nxt_addr = exit_a;
                end else if (e_rem == '0) begin
                    lp_pop   = 1'b1;
                    nxt_addr = exit_a;
                    tmo_hit  = e_match;
                end else begin
                    lp_upd   = 1'b1;
                    lp_wdata = {e_match, e_start, e_rem - 1'b1};
                    nxt_addr = e_start;
                end
            end
            OP_BRK: begin
                if (lp_empty) begin
                    fault = 1'b1;
                end else begin
                    lp_pop   = 1'b1;
                    nxt_addr = tgt;
                end
            end
            OP_JMP:  nxt_addr = tgt;
            OP_BRP:  nxt_addr = flag ? tgt : inc;
            OP_BRF:  nxt_addr = flag ? inc : tgt;
            OP_CALL: begin
                if (rs_full) begin
                    fault = 1'b1;
                end else begin
                    rs_push  = 1'b1;
                    nxt_addr = tgt;
                end
            end
            OP_RET: begin
                if (rs_empty) begin
                    fault = 1'b1;
                end else begin
                    rs_pop   = 1'b1;
                    nxt_addr = rs_top;
                end
            end
            OP_STOP: begin
                stop_hit = 1'b1;
                nxt_addr = addr;
            end
            default: nxt_addr = inc;
        endcase
        if (fault)
            nxt_addr = addr;
    end

endmodule

// File: rtl/pat_seq.sv
// Module: pat_seq (top)
// Pattern address sequencer: holds the current vector address and the run
// state, and owns the loop and return stacks. The instruction fields must
// belong to addr_o in the same cycle (combinational instruction read).
module pat_seq
    import pat_seq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int CW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [AW-1:0] tgt_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          match_i,
    input  logic          flag_i,
    input  logic          ack_i,
    output logic [AW-1:0] addr_o,
    output logic          done_o,
    output logic          err_o,
    output logic          tmo_o
);
    localparam int LW = 1 + AW + CW;

    st_e           state;
    logic          run;
    logic [AW-1:0] nxt_addr;
    logic          lp_push, lp_pop, lp_upd, lp_empty, lp_full;
    logic [LW-1:0] lp_wdata, lp_top;
    logic          rs_push, rs_pop, rs_empty, rs_full;
    logic [AW-1:0] rs_wdata, rs_top;
    logic          stop_hit, fault, tmo_hit;

    assign run    = (state == ST_RUN);
    assign done_o = (state == ST_DONE);

    pat_seq_next #(.AW(AW), .CW(CW)) u_next (
        .op       (op_i),
        .addr     (addr_o),
        .tgt      (tgt_i),
        .cnt      (cnt_i),
        .match    (match_i),
        .flag     (flag_i),
        .lp_top   (lp_top),
        .lp_empty (lp_empty),
        .lp_full  (lp_full),
        .rs_top   (rs_top),
        .rs_empty (rs_empty),
        .rs_full  (rs_full),
        .nxt_addr (nxt_addr),
        .lp_push  (lp_push),
        .lp_pop   (lp_pop),
        .lp_upd   (lp_upd),
        .lp_wdata (lp_wdata),
        .rs_push  (rs_push),
        .rs_pop   (rs_pop),
        .rs_wdata (rs_wdata),
        .stop_hit (stop_hit),
        .fault    (fault),
        .tmo_hit  (tmo_hit)
    );

    pat_seq_lifo #(.W(LW), .DEPTH(DEPTH)) u_loop_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (lp_push & run),
        .pop   (lp_pop & run),
        .upd   (lp_upd & run),
        .wdata (lp_wdata),
        .top   (lp_top),
        .empty (lp_empty),
        .full  (lp_full)
    );

    pat_seq_lifo #(.W(AW), .DEPTH(DEPTH)) u_ret_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rs_push & run),
        .pop   (rs_pop & run),
        .upd   (1'b0),
        .wdata (rs_wdata),
        .top   (rs_top),
        .empty (rs_empty),
        .full  (rs_full)
    );

    // Run state, address register, sticky error and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            addr_o <= '0;
            err_o  <= 1'b0;
            tmo_o  <= 1'b0;
        end else begin
            tmo_o <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (fault) begin
                        state <= ST_HALT;
                        err_o <= 1'b1;
                    end else if (stop_hit) begin
                        state <= ST_DONE;
                    end else begin
                        addr_o <= nxt_addr;
                        tmo_o  <= tmo_hit;
                    end
                end
                ST_DONE: begin
                    if (ack_i) begin
                        state  <= ST_RUN;
                        addr_o <= addr_o + 1'b1;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

endmodule

// File: rtl/pat_seq_chk.sv
// Module: pat_seq_chk
// Port-level protocol checks for pat_seq, attached through bind below.
// Assumes the opcode encodings of pat_seq_pkg.
module pat_seq_chk #(
    parameter int AW = 12,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [AW-1:0] tgt_i,
    input logic          flag_i,
    input logic          ack_i,
    input logic [AW-1:0] addr_o,
    input logic          done_o,
    input logic          err_o,
    input logic          tmo_o
);
    logic active;
    assign active = !done_o && !err_o;

    p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_i == 4'd0) |=> addr_o == $past(addr_o) + 1'b1);

    p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_i == 4'd6) |=> addr_o == $past(tgt_i));

    p_brpass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_i == 4'd7 && flag_i) |=> addr_o == $past(tgt_i));

    p_brfail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_i == 4'd8 && flag_i) |=> addr_o == $past(addr_o) + 1'b1);

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_i == 4'd11) |=> done_o && $stable(addr_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ack_i) |=> done_o && $stable(addr_o));

    p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ack_i) |=> !done_o && addr_o == $past(addr_o) + 1'b1);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o && !done_o && $stable(addr_o));

    p_tmo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> !err_o && !done_o);

endmodule

bind pat_seq pat_seq_chk #(.AW(AW), .CW(CW)) u_pat_seq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .tgt_i  (tgt_i),
    .flag_i (flag_i),
    .ack_i  (ack_i),
    .addr_o (addr_o),
    .done_o (done_o),
    .err_o  (err_o),
    .tmo_o  (tmo_o)
);

// File: tb/test_pat_seq.sv
// Bench for pat_seq: sweeps small programs held in a bench-side vector
// memory and compares the address trace cycle by cycle with traces built
// from the requirement rules.
module test_pat_seq;
    import pat_seq_pkg::*;

    localparam int AW = 6;
    localparam int CW = 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag = 1'b0;
    logic          ack = 1'b0;
    logic          match;
    logic [AW-1:0] addr;
    logic          done, err, tmo;
    logic [3:0]    m_op  [64];
    logic [AW-1:0] m_tgt [64];
    logic [CW-1:0] m_cnt [64];
    logic [AW-1:0] mend_a = '1;
    int            match_after = 1000;
    int            visits;
    int            exp_a [512];
    bit            exp_t [512];
    int            n_exp;
    int            total = 0;
    int            bad = 0;

    always #2 clk = ~clk;

    pat_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) i_pat_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (m_op[addr]),
        .tgt_i   (m_tgt[addr]),
        .cnt_i   (m_cnt[addr]),
        .match_i (match),
        .flag_i  (flag),
        .ack_i   (ack),
        .addr_o  (addr),
        .done_o  (done),
        .err_o   (err),
        .tmo_o   (tmo)
    );

    // Comparator model: match on the n-th execution of the match-loop end.
    assign match = (addr == mend_a) && (visits + 1 == match_after);
    always_ff @(posedge clk) begin
        if (!rst_n) visits <= 0;
        else if (addr == mend_a && !done && !err) visits <= visits + 1;
    end

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic clr_prog();
        for (int a = 0; a < 64; a++) begin
            m_op[a] = OP_ADV; m_tgt[a] = '0; m_cnt[a] = '0;
        end
        mend_a = '1; match_after = 1000; n_exp = 0;
    endtask

    task automatic put(input int a, input logic [3:0] o, input int t, input int c);
        m_op[a] = o; m_tgt[a] = AW'(t); m_cnt[a] = CW'(c);
    endtask

    task automatic pe(input int a, input bit t = 1'b0);
        exp_a[n_exp] = a; exp_t[n_exp] = t; n_exp++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 addr", int'(addr), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 tmo", int'(tmo), 0);
    endtask

    task automatic trace_run(input string tag);
        for (int i = 0; i < n_exp; i++) begin
            chk(tag, int'(addr), exp_a[i]);
            chk({tag, " R4 tmo"}, int'(tmo), int'(exp_t[i]));
            if (i < n_exp - 1) @(negedge clk);
        end
    endtask

    task automatic expect_done(input string tag, input int a);
        @(negedge clk);
        chk({tag, " R10 done"}, int'(done), 1);
        chk({tag, " R10 addr"}, int'(addr), a);
        chk({tag, " R11 no err"}, int'(err), 0);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R3, R2: counted loop sweep; odd sweeps use an unused opcode in the body
        for (int n = 0; n <= 5; n++) begin
            clr_prog();
            put(1, OP_LOOP, 0, n);
            if (n % 2 == 1) put(2, 4'hF, 0, 0);
            put(3, OP_END, 0, 0); put(4, OP_STOP, 0, 0); put(5, OP_STOP, 0, 0);
            pe(0); pe(1);
            for (int k = 0; k < ((n == 0) ? 1 : n); k++) begin pe(2); pe(3); end
            pe(4);
            do_reset();
            trace_run("R3 loop R2 advance");
            expect_done("R3", 4);
            if (n == 2) begin
                repeat (3) @(negedge clk);
                chk("R10 hold addr", int'(addr), 4);
                chk("R10 hold done", int'(done), 1);
                pulse_ack();
                chk("R10 ack addr", int'(addr), 5);
                chk("R10 ack done", int'(done), 0);
            end
        end

        // R4: match loop with limit 3, match on the k-th end
        for (int k = 1; k <= 5; k++) begin
            clr_prog();
            put(0, OP_MLOOP, 0, 3); put(2, OP_END, 0, 0); put(3, OP_STOP, 0, 0);
            mend_a = 2; match_after = k;
            pe(0);
            for (int j = 0; j < ((k < 3) ? k : 3); j++) begin pe(1); pe(2); end
            pe(3, k > 3);
            do_reset();
            trace_run("R4 match loop");
            expect_done("R4", 3);
        end

        // R9, R3: subroutine holding a loop, called from a loop
        for (int o = 1; o <= 3; o++) begin
            for (int i = 1; i <= 3; i++) begin
                clr_prog();
                put(0, OP_LOOP, 0, o); put(1, OP_CALL, 10, 0); put(2, OP_END, 0, 0);
                put(3, OP_STOP, 0, 0);
                put(10, OP_LOOP, 0, i); put(12, OP_END, 0, 0); put(13, OP_RET, 0, 0);
                pe(0);
                for (int a = 0; a < o; a++) begin
                    pe(1); pe(10);
                    for (int b = 0; b < i; b++) begin pe(11); pe(12); end
                    pe(13); pe(2);
                end
                pe(3);
                do_reset();
                trace_run("R9 call/return");
                expect_done("R9", 3);
            end
        end

        // R8, R5: flag branches of both polarities, and a jump
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 2; f++) begin
                bit taken;
                clr_prog();
                put(0, (p == 0) ? OP_BRP : OP_BRF, 5, 0); put(1, OP_JMP, 7, 0);
                put(5, OP_BRF, 9, 0); put(6, OP_STOP, 0, 0); put(7, OP_STOP, 0, 0);
                put(9, OP_STOP, 0, 0);
                flag = f[0];
                taken = (p == 0) ? (f == 1) : (f == 0);
                pe(0);
                if (taken) begin pe(5); pe((f == 1) ? 6 : 9); end
                else begin pe(1); pe(7); end
                do_reset();
                trace_run("R8 branch R5 jump");
                expect_done("R8", exp_a[n_exp - 1]);
            end
        end
        flag = 1'b0;

        // R6: break out of an inner loop; the outer loop keeps its count
        for (int o = 1; o <= 3; o++) begin
            clr_prog();
            put(0, OP_LOOP, 0, o); put(1, OP_LOOP, 0, 9); put(2, OP_BRK, 4, 0);
            put(3, OP_END, 0, 0); put(4, OP_END, 0, 0); put(5, OP_STOP, 0, 0);
            pe(0);
            for (int a = 0; a < o; a++) begin pe(1); pe(2); pe(4); end
            pe(5);
            do_reset();
            trace_run("R6 break");
            expect_done("R6", 5);
        end

        // R7, R11: continue exhausts the loop, then a loop-end underflows
        for (int n = 0; n <= 4; n++) begin
            clr_prog();
            put(0, OP_LOOP, 0, n); put(1, OP_CONT, 3, 0); put(3, OP_STOP, 0, 0);
            put(4, OP_END, 0, 0);
            pe(0);
            for (int a = 0; a < ((n == 0) ? 1 : n); a++) pe(1);
            pe(3);
            do_reset();
            trace_run("R7 continue");
            expect_done("R7", 3);
            pulse_ack();
            chk("R7 resume addr", int'(addr), 4);
            @(negedge clk);
            chk("R11 underflow err", int'(err), 1);
            chk("R11 underflow addr", int'(addr), 4);
            pulse_ack();
            @(negedge clk);
            chk("R11 ack ignored addr", int'(addr), 4);
            chk("R11 ack ignored done", int'(done), 0);
            chk("R11 sticky err", int'(err), 1);
        end

        // R11, R9: DEPTH pushes succeed, the next one overflows
        for (int s = 0; s < 2; s++) begin
            clr_prog();
            for (int a = 0; a <= DEPTH; a++) begin
                if (s == 0) put(a, OP_CALL, a + 1, 0);
                else put(a, OP_LOOP, 0, 2);
                pe(a);
            end
            do_reset();
            trace_run("R11 fill R9 nesting");
            chk("R11 before overflow", int'(err), 0);
            @(negedge clk);
            chk("R11 overflow err", int'(err), 1);
            chk("R11 overflow addr", int'(addr), DEPTH);
            repeat (3) @(negedge clk);
            chk("R11 frozen addr", int'(addr), DEPTH);
        end

        // R11: return on an empty stack
        clr_prog();
        put(0, OP_RET, 0, 0);
        do_reset();
        @(negedge clk);
        chk("R11 ret underflow err", int'(err), 1);
        chk("R11 ret underflow addr", int'(addr), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule